// File: doc/BRIEF.md
# Bidirectional Memory Thermal Pin Controller

This block runs one active-low, open-drain thermal status pin that a pair of memory channels share. A chip with four channels uses two instances: one for channels 0 and 1, and one for channels 2 and 3. The same wire does two jobs. Platform management can pull it low to ask for memory throttling. The block pulls it low itself to warn the platform that a module in its channel pair has become too hot.

On the sensing side, the pad passes through a two-flop synchronizer. A free-running counter, advanced by a 1 MHz tick enable, opens a sense window once every `sense_period` ticks. Typical programming is 100 ticks, that is 100 us. In the window, the state machine `SN_WAIT -> SN_MEASURE` counts consecutive ticks on which the pad is low. A run of `assert_min` ticks (typically 1) raises `throttle_req`. A high pad first clears it. Programming `assert_min` to zero puts the machine in `SN_OFF`. In that state every external assertion is ignored and the pin becomes an output only. Named sense transitions:
- `OFF->WAIT`: the limit becomes nonzero.
- `WAIT->MEASURE`: the period expires.
- `MEASURE->WAIT`: a tick arrives with the pad high, or the required run is met.
- `any->OFF`: the limit is zero.

On the driving side, a level-mode machine moves `DRV_RELEASE -> DRV_PULL` when any module temperature reaches the selected threshold. It moves `DRV_PULL -> DRV_RELEASE` when none does. While the block pulls the pad, and for the two cycles its own release takes to pass the synchronizer, the sensed level is masked. This keeps the block's own alarm from being read back as a throttle request.

Top module: `memhot_pin_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `drive_en` and `throttle_req` are both 0.
- R2: `drive_en` is 1 one clock after any module temperature is greater than or equal to the selected threshold, and 0 one clock after all of them are below it. Equality counts as reached.
- R3: `thr_sel` picks the threshold: 0 = `thr_low`, 1 = `thr_mid`, 2 = `thr_high`, 3 = `thr_oem`.
- R4: The pad is sampled through two flops. A sense window opens once every `sense_period` ticks, and a period of 0 behaves as 1.
- R5: In a window, `throttle_req` becomes 1 when the synchronized pad is low on `assert_min` consecutive ticks. It changes only in cycles where the tick is high.
- R6: A window in which the pad is seen high before `assert_min` low ticks clears `throttle_req` to 0. Low pulses shorter than `assert_min` ticks therefore never set it.
- R7: `throttle_req` keeps its value between sense windows, even if the pad changes.
- R8: With `assert_min` = 0, `throttle_req` is 0 from the next clock and the pad is ignored.
- R9: A low pad caused by the block's own drive, including the two cycles after release, never sets `throttle_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | 1 MHz single-cycle tick enable |
| pad_n_i | input | 1 | Pad level read back (low = asserted) |
| sense_period | input | 16 | Ticks between sense windows |
| assert_min | input | 8 | Consecutive low ticks required; 0 disables sensing |
| thr_low | input | 8 | Low threshold |
| thr_mid | input | 8 | Mid threshold |
| thr_high | input | 8 | High threshold |
| thr_oem | input | 8 | OEM-high threshold |
| thr_sel | input | 2 | Threshold select (0 low, 1 mid, 2 high, 3 OEM-high) |
| dimm_temp | input | 32 | Four 8-bit module temperatures, module 0 in bits 7:0 |
| drive_en | output | 1 | Pull the pad low (open-drain enable) |
| throttle_req | output | 1 | Sensed throttle request |

## Verification
The level output is checked against a table of temperature sets. The table places the hot module in different slots, uses every select value, and includes values one below and exactly at each threshold, which exposes off-by-one and wrong-mux faults. The sense path is driven with several pad patterns:
- A steady low, which must be recognized.
- Low pulses shorter than the required run, which separate a consecutive-run count from an accumulating one.
- A release right after recognition, which shows that the request holds until the next window.
- A low pad with the limit at zero.
- A low pad that comes only from the block's own drive, which separates masking from plain sensing.

// File: rtl/memhot_pkg.sv
package memhot_pkg;

    typedef enum logic [1:0] {
        THR_LOW  = 2'd0,
        THR_MID  = 2'd1,
        THR_HIGH = 2'd2,
        THR_OEM  = 2'd3
    } thr_sel_e;

    typedef enum logic [1:0] {
        SN_OFF     = 2'd0,
        SN_WAIT    = 2'd1,
        SN_MEASURE = 2'd2
    } sense_state_e;

    typedef enum logic {
        DRV_RELEASE = 1'b0,
        DRV_PULL    = 1'b1
    } drv_state_e;

endpackage

// File: rtl/memhot_sync.sv
module memhot_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/memhot_sense_fsm.sv
module memhot_sense_fsm
    import memhot_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int HOLD_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                pin_act_i,
    input  logic [PERIOD_W-1:0] period_cfg_i,
    input  logic [HOLD_W-1:0]   hold_cfg_i,
    output logic                req_o
);
    localparam logic [HOLD_W:0] HOLD_ONE = 1;

    sense_state_e        state_q, state_d;
    logic [PERIOD_W-1:0] pcnt_q;
    logic [PERIOD_W-1:0] plim;
    logic                strobe;
    logic [HOLD_W-1:0]   acnt_q;
    logic                hold_met;
    logic                disabled;

    assign disabled = (hold_cfg_i == '0);
    assign plim     = (period_cfg_i == '0) ? '0 : (period_cfg_i - PERIOD_W'(1));
    assign strobe   = tick_i && (pcnt_q >= plim);
    assign hold_met = (({1'b0, acnt_q} + HOLD_ONE) >= {1'b0, hold_cfg_i});

    // free-running period counter, advanced by tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (tick_i) begin
            pcnt_q <= strobe ? '0 : (pcnt_q + PERIOD_W'(1));
        end
    end

    // consecutive-low tick counter inside a window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acnt_q <= '0;
        end else if (state_q != SN_MEASURE) begin
            acnt_q <= '0;
        end else if (tick_i && pin_act_i && !hold_met) begin
            acnt_q <= acnt_q + HOLD_W'(1);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SN_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (disabled) begin
            state_d = SN_OFF;
        end else begin
            unique case (state_q)
                SN_OFF:     state_d = SN_WAIT;
                SN_WAIT:    if (strobe) state_d = SN_MEASURE;
                SN_MEASURE: if (tick_i && (!pin_act_i || hold_met)) state_d = SN_WAIT;
                default:    state_d = SN_WAIT;
            endcase
        end
    end

    // registered output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_o <= 1'b0;
        end else if (disabled) begin
            req_o <= 1'b0;
        end else if (state_q == SN_MEASURE && tick_i) begin
            if (!pin_act_i) begin
                req_o <= 1'b0;
            end else if (hold_met) begin
                req_o <= 1'b1;
            end
        end
    end

    p_zero_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disabled |=> !req_o);

    p_rise_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(tick_i));

    p_fall_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> ($past(tick_i) || $past(disabled)));

    p_rise_needs_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(pin_act_i));
endmodule

// File: rtl/memhot_level_out.sv
module memhot_level_out
    import memhot_pkg::*;
#(
    parameter int TEMP_W   = 8,
    parameter int NUM_DIMM = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_DIMM*TEMP_W-1:0] temps_i,
    input  logic [TEMP_W-1:0]          thr_low_i,
    input  logic [TEMP_W-1:0]          thr_mid_i,
    input  logic [TEMP_W-1:0]          thr_high_i,
    input  logic [TEMP_W-1:0]          thr_oem_i,
    input  logic [1:0]                 sel_i,
    output logic                       drive_o
);
    logic [TEMP_W-1:0]   limit;
    logic [NUM_DIMM-1:0] over;
    logic                hit;
    drv_state_e          state_q, state_d;

    always_comb begin
        unique case (thr_sel_e'(sel_i))
            THR_LOW:  limit = thr_low_i;
            THR_MID:  limit = thr_mid_i;
            THR_HIGH: limit = thr_high_i;
            THR_OEM:  limit = thr_oem_i;
            default:  limit = thr_oem_i;
        endcase
    end

    for (genvar g = 0; g < NUM_DIMM; g++) begin : g_cmp
        assign over[g] = (temps_i[g*TEMP_W +: TEMP_W] >= limit);
    end

    assign hit = |over;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DRV_RELEASE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRV_RELEASE: if (hit)  state_d = DRV_PULL;
            DRV_PULL:    if (!hit) state_d = DRV_RELEASE;
            default:     state_d = DRV_RELEASE;
        endcase
    end

    // output
    always_comb begin
        drive_o = (state_q == DRV_PULL);
    end

    p_pull_when_hot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> drive_o);

    p_release_when_cool_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !drive_o);
endmodule

// File: rtl/memhot_pin_ctrl.sv
module memhot_pin_ctrl #(
    parameter int TEMP_W   = 8,
    parameter int NUM_DIMM = 4,
    parameter int PERIOD_W = 16,
    parameter int HOLD_W   = 8,
    parameter int SYNC_N   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_1us,
    input  logic                       pad_n_i,
    input  logic [PERIOD_W-1:0]        sense_period,
    input  logic [HOLD_W-1:0]          assert_min,
    input  logic [TEMP_W-1:0]          thr_low,
    input  logic [TEMP_W-1:0]          thr_mid,
    input  logic [TEMP_W-1:0]          thr_high,
    input  logic [TEMP_W-1:0]          thr_oem,
    input  logic [1:0]                 thr_sel,
    input  logic [NUM_DIMM*TEMP_W-1:0] dimm_temp,
    output logic                       drive_en,
    output logic                       throttle_req
);
    logic              pad_sync_n;
    logic [SYNC_N-1:0] drv_hist_q;
    logic              self_mask;
    logic              pin_act;

    memhot_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_n_i),
        .sync_o  (pad_sync_n)
    );

    memhot_level_out #(.TEMP_W(TEMP_W), .NUM_DIMM(NUM_DIMM)) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .temps_i    (dimm_temp),
        .thr_low_i  (thr_low),
        .thr_mid_i  (thr_mid),
        .thr_high_i (thr_high),
        .thr_oem_i  (thr_oem),
        .sel_i      (thr_sel),
        .drive_o    (drive_en)
    );

    // remember own drive as long as it takes to leave the synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_hist_q <= '0;
        end else begin
            drv_hist_q <= {drv_hist_q[SYNC_N-2:0], drive_en};
        end
    end

    assign self_mask = drive_en || (|drv_hist_q);
    assign pin_act   = !pad_sync_n && !self_mask;

    memhot_sense_fsm #(.PERIOD_W(PERIOD_W), .HOLD_W(HOLD_W)) u_sense (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_1us),
        .pin_act_i    (pin_act),
        .period_cfg_i (sense_period),
        .hold_cfg_i   (assert_min),
        .req_o        (throttle_req)
    );

    p_own_drive_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(throttle_req) |-> $past(!drive_en));
endmodule

// File: tb/memhot_pin_ctrl_bench.sv
`timescale 1ns/1ps
module memhot_pin_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  tcnt = '0;
    logic        ext_low = 1'b0;
    logic        pad_n;
    logic [15:0] period = 16'd10;
    logic [7:0]  amin = 8'd3;
    logic [1:0]  sel = 2'd0;
    logic [31:0] temps = '0;
    logic        drive_en, throttle_req;
    int          n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    // tick every 4 clocks
    always @(posedge clk) begin
        tcnt <= tcnt + 2'd1;
        tick <= (tcnt == 2'd3);
    end

    // open-drain pad with external pull-low
    assign pad_n = ~(drive_en | ext_low);

    memhot_pin_ctrl u_memhot_pin_ctrl (
        .clk (clk), .rst_n (rst_n), .tick_1us (tick), .pad_n_i (pad_n),
        .sense_period (period), .assert_min (amin),
        .thr_low (8'd40), .thr_mid (8'd60), .thr_high (8'd80), .thr_oem (8'd100),
        .thr_sel (sel), .dimm_temp (temps),
        .drive_en (drive_en), .throttle_req (throttle_req)
    );

    localparam int NV = 10;
    localparam logic [31:0] VT [NV] = '{
        32'h1E1E1E1E, 32'h1E1E1E28, 32'h1E3B1E1E, 32'h3C1E1E1E, 32'h1E464F1E,
        32'h1E1E551E, 32'h1E1E1E63, 32'h64646464, 32'hFF1E1E1E, 32'h271E1E1E};
    localparam logic [1:0] VS [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2,
                                       2'd2, 2'd3, 2'd3, 2'd0, 2'd0};
    localparam logic VE [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic seen;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 drive in reset", drive_en, 1'b0);
        chk("R1 req in reset", throttle_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 drive after reset", drive_en, 1'b0);
        chk("R1 req after reset", throttle_req, 1'b0);

        // R2/R3: level table
        for (int i = 0; i < NV; i++) begin
            temps = VT[i];
            sel   = VS[i];
            repeat (2) @(negedge clk);
            chk($sformatf("R2/R3 vector %0d", i), drive_en, VE[i]);
        end
        temps = '0;
        sel   = 2'd0;
        repeat (4) @(negedge clk);
        chk("R2 cool release", drive_en, 1'b0);

        // R5/R7/R6: steady low recognized, held, then cleared
        ext_low = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (throttle_req) begin
                seen = 1'b1;
                break;
            end
        end
        chk("R5 steady low sets request", seen, 1'b1);
        ext_low = 1'b0;
        wait_ticks(3);
        chk("R7 request held between windows", throttle_req, 1'b1);
        wait_ticks(30);
        chk("R6 high pad clears request", throttle_req, 1'b0);

        // R8: zero limit disables
        ext_low = 1'b1;
        wait_ticks(30);
        chk("R5 request before disable", throttle_req, 1'b1);
        amin = 8'd0;
        repeat (2) @(negedge clk);
        chk("R8 zero limit clears at once", throttle_req, 1'b0);
        wait_ticks(30);
        chk("R8 pad ignored when disabled", throttle_req, 1'b0);
        ext_low = 1'b0;

        // R6: pulses shorter than the limit
        amin = 8'd3;
        wait_ticks(12);
        seen = 1'b0;
        for (int p = 0; p < 12; p++) begin
            ext_low = 1'b1;
            repeat (8) begin @(negedge clk); seen |= throttle_req; end
            ext_low = 1'b0;
            repeat (8) begin @(negedge clk); seen |= throttle_req; end
        end
        chk("R6 short pulses never set request", seen, 1'b0);

        // R9: own drive is masked
        amin = 8'd1;
        seen = 1'b0;
        temps = 32'h000000FF;
        for (int k = 0; k < 160; k++) begin @(negedge clk); seen |= throttle_req; end
        chk("R9 driving pad low", drive_en, 1'b1);
        temps = '0;
        for (int k = 0; k < 160; k++) begin @(negedge clk); seen |= throttle_req; end
        chk("R9 own drive never sensed", seen, 1'b0);

        // R4: period zero acts as one window per tick
        period = 16'd0;
        ext_low = 1'b1;
        wait_ticks(4);
        chk("R4 period zero still senses", throttle_req, 1'b1);

        // R1: reset mid-operation
        temps = 32'h000000FF;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 drive cleared by reset", drive_en, 1'b0);
        chk("R1 req cleared by reset", throttle_req, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule